// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit works out the data effective address for one memory operand. Its inputs are the decoded addressing mode, the base register number with its value, the index register value, a signed instruction displacement, the address of the next instruction, an access size and a scale shift. It returns the effective address. For the two auto-modify modes it also returns a base-register write-back value with an enable. The register file, the memory access, decode and fault handling are outside the unit.

Each request is marked by `req_valid`. One register stage holds the results, so a request presented at one rising edge shows up on the outputs after that edge, with `res_valid` set. When no request is present the result registers keep their values and `res_valid` goes low. Address arithmetic wraps modulo 2^ADDR_W and no overflow is reported.

Mode codes on `req_mode`: 0 register-direct (no address), 1 immediate (no address), 2 absolute, 3 base plus offset, 4 base plus index, 5 base plus index plus offset, 6 scaled index, 7 register indirect, 8 next-instruction relative, 9 post-increment indirect, 10 pre-decrement indirect, and 11 to 15 unused. Access size code `req_size` selects 1, 2, 4 or 8 bytes for the codes 0 to 3.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode 3 gives base + sign-extended DISP_W-bit displacement.
- R2: When `req_base_sel` is 0 the base operand reads as zero in every mode that uses a base, whatever `req_base_val` holds. Mode 2 gives the sign-extended displacement alone.
- R3: Mode 6 gives base + (index shifted left by `req_scale`, 0 to 3).
- R4: Mode 9 gives the unmodified base as the address, with `res_wb_val` = base + (1 << `req_size`).
- R5: Mode 10 gives base - (1 << `req_size`) as the address, and `res_wb_val` equals that same address.
- R6: Mode 8 gives `req_next_pc` + sign-extended displacement.
- R7: Mode 4 gives base + index, mode 5 gives base + index + sign-extended displacement, and mode 7 gives the base alone.
- R8: All sums and differences wrap modulo 2^ADDR_W.
- R9: `res_wb_en` is 1 only for modes 9 and 10.
- R10: Modes 0, 1 and 11 to 15 set `res_invalid`, drive `res_ea` to zero and clear `res_wb_en`. Every other mode clears `res_invalid`.
- R11: Results appear one clock after a request with `res_valid` = 1. Cycles without a request leave `res_valid` = 0 and every other result output unchanged.
- R12: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 4 | Addressing mode code |
| req_base_sel | input | 5 | Base register number (0 reads as zero) |
| req_base_val | input | 32 | Base register contents |
| req_idx_val | input | 32 | Index register contents |
| req_disp | input | 16 | Signed displacement |
| req_next_pc | input | 32 | Address of the next instruction |
| req_size | input | 2 | Access size code, 1 << code bytes |
| req_scale | input | 2 | Index left-shift amount |
| res_valid | output | 1 | Result registered this cycle |
| res_ea | output | 32 | Effective address |
| res_invalid | output | 1 | Mode has no effective address |
| res_wb_en | output | 1 | Base write-back enable |
| res_wb_val | output | 32 | Base write-back value |

## Verification
The bench builds the unit with its defaults: a 32-bit address, a 16-bit displacement and a 5-bit register number. These widths let base values near 2^32 and negative displacements reach the wrap of R8 on post-increment, pre-decrement and offset sums. The 16-bit field allows the displacement extremes 0x7FFF and 0x8000. All four scale shifts and all four access sizes are driven. Register number 0 is paired with non-zero base values, so a base that leaks through would show in the address.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    MD_REG_DIRECT = 4'd0,
    MD_IMMEDIATE  = 4'd1,
    MD_ABSOLUTE   = 4'd2,
    MD_BASE_OFF   = 4'd3,
    MD_BASE_IDX   = 4'd4,
    MD_BASE_IDX_OFF = 4'd5,
    MD_SCALED     = 4'd6,
    MD_REG_IND    = 4'd7,
    MD_PC_REL     = 4'd8,
    MD_POST_INC   = 4'd9,
    MD_PRE_DEC    = 4'd10
  } ea_mode_e;

  localparam int MODE_W  = 4;
  localparam int SIZE_W  = 2;
  localparam int SCALE_W = 2;
endpackage

// File: rtl/ea_operand_sel.sv
module ea_operand_sel #(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 16,
  parameter int SEL_W   = 5,
  parameter int SCALE_W = 2
) (
  input  logic [SEL_W-1:0]   base_sel,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [ADDR_W-1:0]  idx_val,
  input  logic [DISP_W-1:0]  disp,
  input  logic [SCALE_W-1:0] scale,
  output logic [ADDR_W-1:0]  base_eff,
  output logic [ADDR_W-1:0]  disp_ext,
  output logic [ADDR_W-1:0]  idx_scaled
);
  localparam int NUM_SCALES = 1 << SCALE_W;
  localparam int EXT_W      = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] shifted [NUM_SCALES];

  // register number zero is hard-wired to read as zero
  assign base_eff = (base_sel == '0) ? '0 : base_val;
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

  // one left-shifted copy of the index per scale value, then a mux
  for (genvar g = 0; g < NUM_SCALES; g++) begin : g_shift
    assign shifted[g] = idx_val << g;
  end

  assign idx_scaled = shifted[scale];
endmodule

// File: rtl/ea_combine.sv
module ea_combine
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] base_eff,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [ADDR_W-1:0] idx_scaled,
  input  logic [ADDR_W-1:0] disp_ext,
  input  logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] ea,
  output logic              invalid,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_val
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] term_a;
  logic [ADDR_W-1:0] term_b;
  logic [ADDR_W-1:0] term_c;
  logic [ADDR_W-1:0] sum3;

  assign step = ADDR_W'(1) << size;

  // operand steering into one shared three-input adder
  always_comb begin
    term_a  = '0;
    term_b  = '0;
    term_c  = '0;
    invalid = 1'b0;
    wb_en   = 1'b0;
    unique case (mode)
      MD_ABSOLUTE:     begin term_c = disp_ext; end
      MD_BASE_OFF:     begin term_a = base_eff; term_c = disp_ext; end
      MD_BASE_IDX:     begin term_a = base_eff; term_b = idx_val; end
      MD_BASE_IDX_OFF: begin term_a = base_eff; term_b = idx_val; term_c = disp_ext; end
      MD_SCALED:       begin term_a = base_eff; term_b = idx_scaled; end
      MD_REG_IND:      begin term_a = base_eff; end
      MD_PC_REL:       begin term_a = next_pc; term_c = disp_ext; end
      MD_POST_INC:     begin term_a = base_eff; term_c = step; wb_en = 1'b1; end
      MD_PRE_DEC:      begin term_a = base_eff; term_c = -step; wb_en = 1'b1; end
      default:         begin invalid = 1'b1; end
    endcase
  end

  assign sum3 = term_a + term_b + term_c;

  // post-increment addresses with the old base and writes back the sum
  always_comb begin
    if (mode == MD_POST_INC) begin
      ea     = base_eff;
      wb_val = sum3;
    end else if (mode == MD_PRE_DEC) begin
      ea     = sum3;
      wb_val = sum3;
    end else begin
      ea     = sum3;
      wb_val = '0;
    end
  end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int SEL_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [3:0]         req_mode,
  input  logic [SEL_W-1:0]   req_base_sel,
  input  logic [ADDR_W-1:0]  req_base_val,
  input  logic [ADDR_W-1:0]  req_idx_val,
  input  logic [DISP_W-1:0]  req_disp,
  input  logic [ADDR_W-1:0]  req_next_pc,
  input  logic [1:0]         req_size,
  input  logic [1:0]         req_scale,
  output logic               res_valid,
  output logic [ADDR_W-1:0]  res_ea,
  output logic               res_invalid,
  output logic               res_wb_en,
  output logic [ADDR_W-1:0]  res_wb_val
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] idx_scaled;
  logic [ADDR_W-1:0] ea_c;
  logic              invalid_c;
  logic              wb_en_c;
  logic [ADDR_W-1:0] wb_val_c;

  logic              valid_d, valid_q;
  logic [ADDR_W-1:0] ea_d, ea_q;
  logic              inv_d, inv_q;
  logic              wben_d, wben_q;
  logic [ADDR_W-1:0] wbval_d, wbval_q;

  ea_operand_sel #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .SEL_W(SEL_W), .SCALE_W(SCALE_W)
  ) u_opsel (
    .base_sel   (req_base_sel),
    .base_val   (req_base_val),
    .idx_val    (req_idx_val),
    .disp       (req_disp),
    .scale      (req_scale),
    .base_eff   (base_eff),
    .disp_ext   (disp_ext),
    .idx_scaled (idx_scaled)
  );

  ea_combine #(.ADDR_W(ADDR_W)) u_comb (
    .mode       (req_mode),
    .size       (req_size),
    .base_eff   (base_eff),
    .idx_val    (req_idx_val),
    .idx_scaled (idx_scaled),
    .disp_ext   (disp_ext),
    .next_pc    (req_next_pc),
    .ea         (ea_c),
    .invalid    (invalid_c),
    .wb_en      (wb_en_c),
    .wb_val     (wb_val_c)
  );

  // next-state: load on a request, otherwise hold results
  always_comb begin
    valid_d = req_valid;
    ea_d    = ea_q;
    inv_d   = inv_q;
    wben_d  = wben_q;
    wbval_d = wbval_q;
    if (req_valid) begin
      ea_d    = ea_c;
      inv_d   = invalid_c;
      wben_d  = wb_en_c;
      wbval_d = wb_val_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ea_q    <= '0;
      inv_q   <= 1'b0;
      wben_q  <= 1'b0;
      wbval_q <= '0;
    end else begin
      valid_q <= valid_d;
      ea_q    <= ea_d;
      inv_q   <= inv_d;
      wben_q  <= wben_d;
      wbval_q <= wbval_d;
    end
  end

  assign res_valid   = valid_q;
  assign res_ea      = ea_q;
  assign res_invalid = inv_q;
  assign res_wb_en   = wben_q;
  assign res_wb_val  = wbval_q;

  // R11: a result is flagged exactly one cycle after each request
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid) == res_valid);

  // R11: idle cycles leave the address unchanged
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_ea) && $stable(res_wb_val));

  // R9: write-back only for the auto-modify modes
  p_wb_only_automod_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode != MD_POST_INC && req_mode != MD_PRE_DEC |=> !res_wb_en);

  // R5: pre-decrement writes back the address it used
  p_predec_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == MD_PRE_DEC |=> res_wb_en && res_wb_val == res_ea);

  // R4: post-increment advances the base by the access size
  p_postinc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == MD_POST_INC |=>
      res_wb_val == res_ea + (ADDR_W'(1) << $past(req_size)));

  // R6: relative to the next instruction address
  p_pcrel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == MD_PC_REL |=>
      res_ea == $past(req_next_pc) +
        {{EXT_W{$past(req_disp[DISP_W-1])}}, $past(req_disp)});

  // R10: invalid modes give a zero address
  p_invalid_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_mode < 4'd2 || req_mode > 4'd10) |=>
      res_invalid && res_ea == '0 && !res_wb_en);

  // R2: register zero as indirect base reads zero
  p_r0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == MD_REG_IND && req_base_sel == '0 |=> res_ea == '0);
endmodule

// File: tb/ea_gen_unit_test.sv
`timescale 1ns/1ps
module ea_gen_unit_test;
  typedef struct {
    logic [31:0] ea;
    logic        inv;
    logic        wben;
    logic [31:0] wbval;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_mode;
  logic [4:0]  req_base_sel;
  logic [31:0] req_base_val, req_idx_val, req_next_pc;
  logic [15:0] req_disp;
  logic [1:0]  req_size, req_scale;
  logic        res_valid, res_invalid, res_wb_en;
  logic [31:0] res_ea, res_wb_val;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  ea_gen_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_base_sel(req_base_sel), .req_base_val(req_base_val),
    .req_idx_val(req_idx_val), .req_disp(req_disp), .req_next_pc(req_next_pc),
    .req_size(req_size), .req_scale(req_scale), .res_valid(res_valid),
    .res_ea(res_ea), .res_invalid(res_invalid), .res_wb_en(res_wb_en),
    .res_wb_val(res_wb_val)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // driver: apply one request and push the independently computed result
  task automatic drive(input string tag, input logic [3:0] m, input logic [4:0] sel,
                       input logic [31:0] b, input logic [31:0] x,
                       input logic [15:0] d, input logic [31:0] pc,
                       input logic [1:0] sz, input logic [1:0] sc);
    exp_t e;
    logic [31:0] bb, dd, st;
    bb = (sel == 5'd0) ? 32'd0 : b;
    dd = {{16{d[15]}}, d};
    st = 32'd1 << sz;
    e.tag = tag; e.inv = 1'b0; e.wben = 1'b0; e.wbval = 32'd0;
    case (m)
      4'd2:  e.ea = dd;
      4'd3:  e.ea = bb + dd;
      4'd4:  e.ea = bb + x;
      4'd5:  e.ea = bb + x + dd;
      4'd6:  e.ea = bb + (x << sc);
      4'd7:  e.ea = bb;
      4'd8:  e.ea = pc + dd;
      4'd9:  begin e.ea = bb; e.wben = 1'b1; e.wbval = bb + st; end
      4'd10: begin e.ea = bb - st; e.wben = 1'b1; e.wbval = bb - st; end
      default: begin e.ea = 32'd0; e.inv = 1'b1; end
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_base_sel = sel; req_base_val = b;
    req_idx_val = x; req_disp = d; req_next_pc = pc; req_size = sz; req_scale = sc;
    q.push_back(e);
  endtask

  // monitor: compare every flagged result against the queue head
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11 unexpected result", {31'd0, res_valid}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(res_ea == e.ea, {e.tag, " ea"}, res_ea, e.ea);
        chk(res_invalid == e.inv, {e.tag, " R10 invalid"}, {31'd0, res_invalid}, {31'd0, e.inv});
        chk(res_wb_en == e.wben, {e.tag, " R9 wb_en"}, {31'd0, res_wb_en}, {31'd0, e.wben});
        if (e.wben)
          chk(res_wb_val == e.wbval, {e.tag, " wb_val"}, res_wb_val, e.wbval);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_ea;
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 4'd0; req_base_sel = 5'd0;
    req_base_val = 32'd0; req_idx_val = 32'd0; req_disp = 16'd0;
    req_next_pc = 32'd0; req_size = 2'd0; req_scale = 2'd0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(res_valid == 1'b0 && res_invalid == 1'b0 && res_wb_en == 1'b0,
        "R12 reset flags", {29'd0, res_valid, res_invalid, res_wb_en}, 32'd0);
    chk(res_ea == 32'd0 && res_wb_val == 32'd0, "R12 reset values", res_ea | res_wb_val, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    drive("R1 positive disp", 4'd3, 5'd4, 32'h0000_1000, 32'd0, 16'h0010, 32'd0, 2'd0, 2'd0);
    drive("R1 negative disp", 4'd3, 5'd4, 32'h0000_1000, 32'd0, 16'hFFF0, 32'd0, 2'd0, 2'd0);
    drive("R1 disp max",      4'd3, 5'd7, 32'h1234_0000, 32'd0, 16'h7FFF, 32'd0, 2'd0, 2'd0);
    drive("R1 disp min",      4'd3, 5'd7, 32'h1234_0000, 32'd0, 16'h8000, 32'd0, 2'd0, 2'd0);
    drive("R2 r0 base off",   4'd3, 5'd0, 32'hDEAD_BEEF, 32'd0, 16'h0040, 32'd0, 2'd0, 2'd0);
    drive("R2 absolute",      4'd2, 5'd9, 32'hDEAD_BEEF, 32'd0, 16'h8004, 32'd0, 2'd0, 2'd0);
    drive("R2 r0 indirect",   4'd7, 5'd0, 32'hFFFF_FFFF, 32'd0, 16'd0, 32'd0, 2'd0, 2'd0);
    for (int s = 0; s < 4; s++)
      drive("R3 scaled", 4'd6, 5'd3, 32'h0000_8000, 32'h0000_0013, 16'd0, 32'd0, 2'd0, 2'(s));
    for (int s = 0; s < 4; s++)
      drive("R4 post-inc", 4'd9, 5'd2, 32'h0000_2000, 32'd0, 16'd0, 32'd0, 2'(s), 2'd0);
    for (int s = 0; s < 4; s++)
      drive("R5 pre-dec", 4'd10, 5'd2, 32'h0000_2000, 32'd0, 16'd0, 32'd0, 2'(s), 2'd0);
    drive("R6 pc-rel fwd",    4'd8, 5'd1, 32'h5555_0000, 32'd0, 16'h0100, 32'h0000_4004, 2'd0, 2'd0);
    drive("R6 pc-rel back",   4'd8, 5'd1, 32'h5555_0000, 32'd0, 16'hFF00, 32'h0000_4004, 2'd0, 2'd0);
    drive("R7 base+idx",      4'd4, 5'd5, 32'h0001_0000, 32'h0000_0222, 16'h0033, 32'd0, 2'd0, 2'd3);
    drive("R7 base+idx+off",  4'd5, 5'd5, 32'h0001_0000, 32'h0000_0222, 16'hFFFE, 32'd0, 2'd0, 2'd0);
    drive("R7 reg indirect",  4'd7, 5'd5, 32'hCAFE_0010, 32'd0, 16'h0044, 32'd0, 2'd0, 2'd0);
    drive("R8 wrap add",      4'd5, 5'd6, 32'hFFFF_FFF0, 32'h0000_0020, 16'h0004, 32'd0, 2'd0, 2'd0);
    drive("R8 wrap post-inc", 4'd9, 5'd6, 32'hFFFF_FFFC, 32'd0, 16'd0, 32'd0, 2'd3, 2'd0);
    drive("R8 wrap pre-dec",  4'd10, 5'd6, 32'h0000_0002, 32'd0, 16'd0, 32'd0, 2'd2, 2'd0);
    drive("R8 wrap neg disp", 4'd3, 5'd6, 32'h0000_0004, 32'd0, 16'hFFF0, 32'd0, 2'd0, 2'd0);
    drive("R10 reg direct",   4'd0, 5'd6, 32'h1111_1111, 32'h2, 16'h0003, 32'h4, 2'd1, 2'd1);
    drive("R10 immediate",    4'd1, 5'd6, 32'h1111_1111, 32'h2, 16'h0003, 32'h4, 2'd1, 2'd1);
    for (int m = 11; m < 16; m++)
      drive("R10 unused mode", 4'(m), 5'd6, 32'h1111_1111, 32'h2, 16'h0003, 32'h4, 2'd1, 2'd1);
    drive("R9 post-inc r0",   4'd9, 5'd0, 32'h7777_7777, 32'd0, 16'd0, 32'd0, 2'd1, 2'd0);

    // R11: idle cycles, garbage on inputs, results must hold
    @(negedge clk);
    req_valid = 1'b0; req_mode = 4'd3; req_base_sel = 5'd8; req_base_val = 32'h0BAD_0BAD;
    @(negedge clk);
    held_ea = res_ea;
    chk(q.size() == 0, "R11 all results seen", q.size(), 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R11 idle valid low", {31'd0, res_valid}, 32'd0);
      chk(res_ea == held_ea, "R11 idle hold", res_ea, held_ea);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule